// File: doc/BRIEF.md
# Programmable Parallel Port Controller

This block connects a processor bus to three 8-bit peripheral ports, A, B and C. Port C is treated as two nibbles. The ports are arranged in two groups: group A is port A with the upper nibble of C, and group B is port B with the lower nibble of C. A control register sets each group's operating mode and the direction of each port or nibble. In the plain mode, outputs come from a latch and inputs are read live from the pins. In the handshake mode, ports A and B each take three port C lines. These lines carry a strobe or acknowledge from the peripheral, a buffer-full indication and an interrupt request.

The processor side is synchronous to `clk`. A write takes effect once, on the first clock edge that sees chip select and the write strobe both low. A read returns data combinationally for as long as chip select and the read strobe are both low. The block registers the start and the end of each read, because the handshake flags depend on them. The peripheral strobe and acknowledge pins are assumed to be synchronous to `clk`.

Top module: `ppi_core`

## Requirements
- R1: `addr` selects 0 = port A, 1 = port B, 2 = port C, 3 = control. An access needs `cs_n` low together with `rd_n` or `wr_n` low. A write commits once per strobe assertion. `dout` is 0 when no read is active.
- R2: A control write with bit 7 set defines the mode. Bits 6..5 give the group A mode: 00 plain, 01 handshake; codes 1x are rejected and change nothing. Bit 4 is the port A direction and bit 3 the upper C direction. Bit 2 gives the group B mode (1 = handshake). Bit 1 is the port B direction and bit 0 the lower C direction. A direction bit of 1 means input (output enable low).
- R3: After reset every port is an input in plain mode, and every latch, flag and interrupt enable is 0. A mode-definition write also clears all latches, flags and enables.
- R4: In plain mode an output port drives its latch, and a read returns the latch. A read of an input port returns the live pins.
- R5: A control write with bit 7 clear sets port C latch bit `din[3:1]` to the value `din[0]`.
- R6: A handshake input port loads its pins into the latch and sets buffer-full on each clock with the strobe low. A data read then returns the latched value, even after the pins change.
- R7: A handshake input raises its interrupt one clock after the strobe returns high, if its enable is set. The leading edge of a data read clears the interrupt. The trailing edge clears buffer-full, unless the strobe is low in that same cycle, in which case buffer-full stays set.
- R8: A data write to a handshake output port drives its active-low buffer-full line low and clears its interrupt. Acknowledge low returns that line high. Acknowledge returning high raises the interrupt if the enable is set.
- R9: Line use in handshake mode. Port A input: C4 strobe in, C5 buffer-full out, C3 interrupt out. Port A output: C6 acknowledge in, C7 active-low buffer-full out, C3 interrupt out. Port B: C2 strobe/acknowledge in, C1 buffer-full out, C0 interrupt out. The enable is the port C latch bit at the strobe/acknowledge position. Unclaimed C lines behave as in plain mode.
- R10: A port C read in handshake mode returns interrupt, enable and buffer-full on the claimed positions of R9, and the plain value elsewhere. A port C data write leaves the claimed latch bits untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Register select |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, 0 when idle |
| pa_in | input | 8 | Port A pins |
| pa_out | output | 8 | Port A drive value |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B pins |
| pb_out | output | 8 | Port B drive value |
| pb_oe | output | 8 | Port B output enables |
| pc_in | input | 8 | Port C pins, including strobe/acknowledge inputs |
| pc_out | output | 8 | Port C drive value, including handshake outputs |
| pc_oe | output | 8 | Port C output enables |

## Verification
Two events can fall in the same clock: the trailing edge of a processor read, which empties the input buffer, and a new peripheral strobe, which fills it. The bench provokes this by releasing the read strobe on the same falling clock edge that pulls the port A strobe low. It judges the result from the C5 buffer-full pin one cycle later, which must still be high. A further strobe-free read must then clear it.

// File: rtl/ppi_core.sv
module ppi_core (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       rd_n,
  input  logic       wr_n,
  input  logic [1:0] addr,
  input  logic [7:0] din,
  output logic [7:0] dout,
  input  logic [7:0] pa_in,
  output logic [7:0] pa_out,
  output logic [7:0] pa_oe,
  input  logic [7:0] pb_in,
  output logic [7:0] pb_out,
  output logic [7:0] pb_oe,
  input  logic [7:0] pc_in,
  output logic [7:0] pc_out,
  output logic [7:0] pc_oe
);
  logic       rd_act, wr_act, rd_q, wr_q, wr_go, mdef, bsr;
  logic [1:0] rd_sel_q;
  logic       a_hs, a_in, cu_in, b_hs, b_in, cl_in;
  logic [7:0] pc_lat, claim, pc_rd, pc_drv, pc_en;
  logic [1:0] hs_mode, is_in, inte, hs_pin, rd_lead, rd_trail, wr_lead, ibf, obf, intr;
  logic [7:0] pin_d [2];
  logic [7:0] lat   [2];

  assign rd_act  = !cs_n && !rd_n;
  assign wr_act  = !cs_n && !wr_n;
  assign wr_go   = wr_act && !wr_q;
  assign mdef    = wr_go && addr == 2'd3 && din[7] && !din[6];
  assign bsr     = wr_go && addr == 2'd3 && !din[7];
  assign hs_mode = {b_hs, a_hs};
  assign is_in   = {b_in, a_in};
  assign inte    = {pc_lat[2], a_in ? pc_lat[4] : pc_lat[6]};
  assign hs_pin  = {pc_in[2],  a_in ? pc_in[4]  : pc_in[6]};
  assign pin_d[0] = pa_in;
  assign pin_d[1] = pb_in;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rd_q <= 1'b0;
      wr_q <= 1'b0;
      rd_sel_q <= 2'd0;
      {a_hs, a_in, cu_in, b_hs, b_in, cl_in} <= 6'b011011;
      pc_lat <= 8'h00;
    end else begin
      rd_q <= rd_act;
      wr_q <= wr_act;
      if (rd_act && !rd_q) rd_sel_q <= addr;
      if (mdef) begin
        {a_hs, a_in, cu_in, b_hs, b_in, cl_in} <= {din[5], din[4:0]};
        pc_lat <= 8'h00;
      end else if (bsr)
        pc_lat[din[3:1]] <= din[0];
      else if (wr_go && addr == 2'd2)
        pc_lat <= (pc_lat & claim) | (din & ~claim);
    end

  for (genvar g = 0; g < 2; g++) begin : g_ch
    logic       ibf_r, obf_r, intr_r, hs_q, rise;
    logic [7:0] lat_r;

    assign rd_lead[g]  = rd_act && !rd_q && addr == 2'(g);
    assign rd_trail[g] = rd_q && !rd_act && rd_sel_q == 2'(g);
    assign wr_lead[g]  = wr_go && addr == 2'(g);
    assign rise        = !hs_q && hs_pin[g];
    assign lat[g]  = lat_r;
    assign ibf[g]  = ibf_r;
    assign obf[g]  = obf_r;
    assign intr[g] = intr_r;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        ibf_r <= 1'b0; obf_r <= 1'b0; intr_r <= 1'b0; lat_r <= 8'h00; hs_q <= 1'b1;
      end else begin
        hs_q <= hs_pin[g];
        if (mdef) begin
          ibf_r <= 1'b0; obf_r <= 1'b0; intr_r <= 1'b0; lat_r <= 8'h00;
        end else if (!hs_mode[g]) begin
          if (wr_lead[g]) lat_r <= din;
        end else if (is_in[g]) begin
          if (!hs_pin[g]) begin
            lat_r <= pin_d[g];
            ibf_r <= 1'b1;
          end else if (rd_trail[g])
            ibf_r <= 1'b0;
          if (rd_lead[g]) intr_r <= 1'b0;
          else if (rise && inte[g]) intr_r <= 1'b1;
        end else begin
          if (wr_lead[g]) begin
            lat_r <= din; obf_r <= 1'b1; intr_r <= 1'b0;
          end else begin
            if (!hs_pin[g]) obf_r <= 1'b0;
            if (rise && inte[g]) intr_r <= 1'b1;
          end
        end
      end

    p_stb_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
      hs_mode[g] && is_in[g] && !hs_pin[g] && !mdef |=> ibf_r && lat_r == $past(pin_d[g]));
    p_rd_clr_intr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      hs_mode[g] && is_in[g] && rd_lead[g] && !mdef |=> !intr_r);
    p_intr_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(intr_r) |-> $past(inte[g]));
    p_wr_obf_r8: assert property (@(posedge clk) disable iff (!rst_n)
      hs_mode[g] && !is_in[g] && wr_lead[g] |=> obf_r && !intr_r);
    p_mdef_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mdef |=> !ibf_r && !obf_r && !intr_r && lat_r == 8'h00);
  end

  always_comb begin
    pc_drv = pc_lat;
    pc_en  = {{4{!cu_in}}, {4{!cl_in}}};
    pc_rd  = {cu_in ? pc_in[7:4] : pc_lat[7:4], cl_in ? pc_in[3:0] : pc_lat[3:0]};
    claim  = 8'h00;
    if (a_hs) begin
      claim[3] = 1'b1; pc_drv[3] = intr[0]; pc_en[3] = 1'b1; pc_rd[3] = intr[0];
      if (a_in) begin
        claim[5:4] = 2'b11;
        pc_drv[5] = ibf[0]; pc_en[5] = 1'b1; pc_en[4] = 1'b0;
        pc_rd[5] = ibf[0];  pc_rd[4] = pc_lat[4];
      end else begin
        claim[7:6] = 2'b11;
        pc_drv[7] = !obf[0]; pc_en[7] = 1'b1; pc_en[6] = 1'b0;
        pc_rd[7] = !obf[0];  pc_rd[6] = pc_lat[6];
      end
    end
    if (b_hs) begin
      claim[2:0] = 3'b111;
      pc_drv[0] = intr[1];
      pc_drv[1] = b_in ? ibf[1] : !obf[1];
      pc_en[2:0] = 3'b011;
      pc_rd[0] = intr[1]; pc_rd[1] = pc_drv[1]; pc_rd[2] = pc_lat[2];
    end
  end

  always_comb begin
    dout = 8'h00;
    if (rd_act)
      case (addr)
        2'd0:    dout = (a_in && !a_hs) ? pa_in : lat[0];
        2'd1:    dout = (b_in && !b_hs) ? pb_in : lat[1];
        2'd2:    dout = pc_rd;
        default: dout = 8'h00;
      endcase
  end

  assign pa_out = lat[0];
  assign pb_out = lat[1];
  assign pa_oe  = {8{!a_in}};
  assign pb_oe  = {8{!b_in}};
  assign pc_out = pc_drv;
  assign pc_oe  = pc_en;

  p_claim_lines_r9: assert property (@(posedge clk) disable iff (!rst_n)
    a_hs && a_in |-> !pc_oe[4] && pc_oe[5] && pc_oe[3]);
  p_idle_dout_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || (rd_n && wr_n)) |-> dout == 8'h00);
endmodule

// File: tb/ppi_core_test.sv
`timescale 1ns/1ps
module ppi_core_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] addr = 2'd0;
  logic [7:0] din = 8'h00;
  logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'hFF;
  logic [7:0] dout, pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;
  int checks = 0, failures = 0;
  logic [7:0] v;

  always #2 clk = ~clk;

  ppi_core uut (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .din(din), .dout(dout), .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe), .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe));

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); cs_n = 1'b0; addr = a; din = d; wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1; cs_n = 1'b1;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); cs_n = 1'b0; addr = a; rd_n = 1'b0;
    #1 d = dout;
    @(negedge clk); rd_n = 1'b1; cs_n = 1'b1;
  endtask

  task automatic pulse_c(input int idx);
    @(negedge clk); pc_in[idx] = 1'b0;
    @(negedge clk); pc_in[idx] = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset;
    check("R3 pa_oe after reset", pa_oe, 8'h00);
    check("R3 pb_oe after reset", pb_oe, 8'h00);
    check("R3 pc_oe after reset", pc_oe, 8'h00);
    check("R3 pa_out after reset", pa_out, 8'h00);
    check("R1 idle dout", dout, 8'h00);
    pa_in = 8'h5A;
    bus_rd(2'd0, v);
    check("R4 live read after reset", v, 8'h5A);
  endtask

  task automatic t_plain;
    bus_wr(2'd3, 8'h80);
    bus_wr(2'd0, 8'h3C);
    check("R4 pa_out latch", pa_out, 8'h3C);
    check("R2 pa_oe output", pa_oe, 8'hFF);
    bus_rd(2'd0, v);
    check("R4 read output latch", v, 8'h3C);
    bus_wr(2'd2, 8'h96);
    check("R4 pc_out latch", pc_out, 8'h96);
    check("R2 pc_oe output", pc_oe, 8'hFF);
    @(negedge clk); cs_n = 1'b1; addr = 2'd0; din = 8'hFF; wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1;
    check("R1 write without select ignored", pa_out, 8'h3C);
    bus_wr(2'd3, 8'hC0);
    check("R2 rejected code keeps latch", pa_out, 8'h3C);
    check("R2 rejected code keeps dir", pa_oe, 8'hFF);
    bus_wr(2'd3, 8'h88);
    check("R2 nibble directions", pc_oe, 8'h0F);
    check("R3 mode write clears latch", pa_out, 8'h00);
    pc_in = 8'h5A;
    bus_rd(2'd2, v);
    check("R4 port C mixed read", v, 8'h50);
    pc_in = 8'hFF;
    bus_wr(2'd3, 8'h90);
    check("R2 port A input dir", pa_oe, 8'h00);
    pa_in = 8'hA7;
    bus_rd(2'd0, v);
    check("R4 unlatched read 1", v, 8'hA7);
    pa_in = 8'h3B;
    bus_rd(2'd0, v);
    check("R4 unlatched read 2", v, 8'h3B);
  endtask

  task automatic t_bitset;
    bus_wr(2'd3, 8'h80);
    bus_wr(2'd3, 8'h0F);
    check("R5 set bit 7", pc_out, 8'h80);
    bus_wr(2'd3, 8'h05);
    check("R5 set bit 2", pc_out, 8'h84);
    bus_wr(2'd3, 8'h0E);
    check("R5 clear bit 7", pc_out, 8'h04);
  endtask

  task automatic t_strobe_in;
    pc_in = 8'hFF;
    bus_wr(2'd3, 8'hB0);
    check("R9 A input line enables", pc_oe, 8'hEF);
    bus_wr(2'd3, 8'h09);
    pa_in = 8'hC3;
    pulse_c(4);
    check("R6 buffer-full on C5", {7'd0, pc_out[5]}, 8'h01);
    check("R7 interrupt on C3", {7'd0, pc_out[3]}, 8'h01);
    pa_in = 8'h00;
    bus_rd(2'd2, v);
    check("R10 port C status read", v, 8'h38);
    bus_rd(2'd0, v);
    check("R6 latched data", v, 8'hC3);
    #1 check("R7 read clears interrupt", {7'd0, pc_out[3]}, 8'h00);
    check("R7 buffer-full held until trailing edge", {7'd0, pc_out[5]}, 8'h01);
    @(negedge clk);
    check("R7 trailing edge clears buffer-full", {7'd0, pc_out[5]}, 8'h00);
    bus_wr(2'd3, 8'h08);
    pulse_c(4);
    check("R7 disabled: full set", {7'd0, pc_out[5]}, 8'h01);
    check("R7 disabled: no interrupt", {7'd0, pc_out[3]}, 8'h00);
    // R7 collision: read trailing edge with strobe low
    @(negedge clk); cs_n = 1'b0; addr = 2'd0; rd_n = 1'b0;
    @(negedge clk); rd_n = 1'b1; cs_n = 1'b1; pc_in[4] = 1'b0;
    @(negedge clk);
    check("R7 collision keeps buffer-full", {7'd0, pc_out[5]}, 8'h01);
    pc_in[4] = 1'b1;
    bus_rd(2'd0, v);
    @(negedge clk);
    check("R7 later read empties buffer", {7'd0, pc_out[5]}, 8'h00);
    bus_wr(2'd2, 8'hFF);
    check("R10 data write unclaimed bits", pc_out & 8'hC7, 8'hC7);
    bus_rd(2'd2, v);
    check("R10 claimed bits untouched", v, 8'hC7);
  endtask

  task automatic t_strobe_out;
    pc_in = 8'hFF;
    bus_wr(2'd3, 8'h84);
    bus_wr(2'd3, 8'h05);
    bus_wr(2'd1, 8'h7E);
    check("R8 port B data", pb_out, 8'h7E);
    check("R8 buffer-full low after write", pc_out, 8'h04);
    bus_rd(2'd2, v);
    check("R10 port B status read", v, 8'h04);
    @(negedge clk); pc_in[2] = 1'b0;
    @(negedge clk);
    check("R8 acknowledge returns line high", {7'd0, pc_out[1]}, 8'h01);
    check("R8 no interrupt while ack low", {7'd0, pc_out[0]}, 8'h00);
    pc_in[2] = 1'b1;
    @(negedge clk);
    check("R8 interrupt on C0", {7'd0, pc_out[0]}, 8'h01);
    bus_rd(2'd2, v);
    check("R10 port B status after ack", v, 8'h07);
    bus_wr(2'd1, 8'h11);
    check("R8 write clears interrupt", pc_out, 8'h04);
    bus_wr(2'd3, 8'h04);
    pulse_c(2);
    check("R8 disabled ack: no interrupt", pc_out, 8'h02);
    bus_wr(2'd3, 8'hA0);
    check("R9 A output line enables", pc_oe, 8'hBF);
    bus_wr(2'd0, 8'h55);
    check("R9 A buffer-full on C7", {7'd0, pc_out[7]}, 8'h00);
    pulse_c(6);
    check("R9 A ack on C6", {7'd0, pc_out[7]}, 8'h01);
  endtask

  initial begin
    #800000;
    failures++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_plain();
    t_bitset();
    t_strobe_in();
    t_strobe_out();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule